// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a retriggerable one-shot watchdog for a small controller. After power-on it stays idle. The first kick pulse arms it, and every later kick restarts the count. If the count reaches the selected terminal value before a kick arrives, the block emits a one-cycle system reset pulse. After that pulse the watchdog returns to the idle state, unless permanent mode is strapped on.

A five-bit mode register sets four things:

- the timeout tap;
- whether counting continues while the CPU is halted;
- whether counting continues while the CPU is stopped;
- which tick source advances the counter: the internal RC tick or the external clock-pin tick.

Software can change this register only during a short window. The window opens after power-on reset, after a watchdog reset, or after a wake from STOP. The permanent-enable strap makes the watchdog active straight out of reset and overrides the tap and gating bits.

A watchdog reset raised while the CPU is in STOP also raises a context-keep flag. Neighbouring wake-control and port registers use that flag to skip their reinitialisation. The mode register in this block is never cleared by a watchdog reset.

Top module: `mode_watchdog`

## Requirements
- R1: After `rst_n` is sampled low, `wdt_rst` and `stop_keep` are 0, `cfg_q` is 5'b00101 and `win_open` is 1.
- R2: `cfg_q[1:0]` picks the timeout in selected-source ticks: 00 = 128, 01 = 256, 10 = 512, 11 = 2048. With a tick on every cycle, `wdt_rst` rises exactly that many clock edges after the kick edge.
- R3: Without permanent mode, no reset is ever produced before the first kick. A kick clears the count, so the timeout restarts from the latest kick.
- R4: `wdt_rst` is high for exactly one cycle. Afterwards the watchdog is idle and produces no further reset until it is kicked again.
- R5: A kick sampled on the same edge as the terminal count suppresses the reset and restarts the count.
- R6: With `halt_mode` high and `stop_mode` low, the count advances only if `cfg_q[2]` is 1.
- R7: With `stop_mode` high, the count advances only if `cfg_q[3]` is 1 and `cfg_q[4]` is 0. When the external source is selected, the count always freezes in STOP.
- R8: `cfg_q[4]` = 1 counts `xt_tick` and ignores `rc_tick`. `cfg_q[4]` = 0 does the reverse.
- R9: A write through `cfg_we` is accepted only on the first 60 clock edges after `rst_n` release, after a `wdt_rst` pulse, or after a `stop_wake` pulse. `win_open` shows the window, and writes outside it leave `cfg_q` unchanged.
- R10: With `perm_en` strapped high, the watchdog is armed from reset and re-arms itself after each reset pulse. It uses the 256 tick timeout, counts in HALT, and ignores `cfg_q[3:0]`. In STOP it counts only when `cfg_q[4]` is 0.
- R11: A reset pulse raised while `stop_mode` is high is accompanied by `stop_keep` in the same cycle, and `cfg_q` keeps its value across it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| perm_en | input | 1 | Permanent-enable strap, changed only during reset |
| rc_tick | input | 1 | Count enable from the internal RC source |
| xt_tick | input | 1 | Count enable from the external clock pin |
| halt_mode | input | 1 | CPU is in HALT |
| stop_mode | input | 1 | CPU is in STOP |
| stop_wake | input | 1 | One-cycle pulse on wake from STOP; reopens the write window |
| kick | input | 1 | Arm and refresh pulse |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 5 | Mode register write data |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| stop_keep | output | 1 | Reset pulse occurred in STOP; neighbours keep their context |
| cfg_q | output | 5 | Current mode register |
| win_open | output | 1 | Write window is open |

## Verification
A wrong internal count appears at `wdt_rst` as a pulse a few edges early or late. A wrong armed flag appears as a spurious pulse while idle, or a missing one after a kick, and this is visible no later than one full timeout after the kick. A window counter that is off by one shows as a write accepted or refused on the 60th or 61st edge, and `cfg_q` shows this on the next cycle. Gating errors in HALT or STOP shift the pulse by exactly the number of gated cycles, so each timeout is measured from the kick edge to the pulse edge.

// File: rtl/wdt_pkg.sv
// Shared types and helpers for the watchdog.
// Assumes the mode register is five bits, with the field positions fixed
// by software convention: src[4] stop[3] halt[2] tap[1:0].
package wdt_pkg;

    typedef struct packed {
        logic       src_ext;   // 1: external clock-pin tick, 0: RC tick
        logic       stop_run;  // count while in STOP (RC source only)
        logic       halt_run;  // count while in HALT
        logic [1:0] tap;       // timeout select
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_RESET = '{src_ext: 1'b0, stop_run: 1'b0,
                                       halt_run: 1'b1, tap: 2'b01};

    localparam logic [1:0] PERM_TAP = 2'b01;

    // Extra doublings above the base timeout for each tap code.
    function automatic int unsigned tap_shift(input logic [1:0] t);
        return (t == 2'b11) ? 4 : int'(t);
    endfunction

endpackage

// File: rtl/wdt_mode_reg.sv
// Mode register with a write window.
// The window opens for WIN_CYCLES edges after reset and after each reopen
// pulse. Writes outside the window are dropped. Only rst_n initialises the
// register, so a watchdog reset leaves it intact.
module wdt_mode_reg
    import wdt_pkg::*;
#(
    parameter int WIN_CYCLES = 60
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  wdt_cfg_t wr_data,
    input  logic     reopen,
    output wdt_cfg_t cfg,
    output logic     win_open
);
    localparam int WIN_W = $clog2(WIN_CYCLES + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES);

    logic [WIN_W-1:0] win_cnt;

    assign win_open = (win_cnt < WIN_LAST);

    // Window age counter: cleared on reset or reopen, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)        win_cnt <= '0;
        else if (reopen)   win_cnt <= '0;
        else if (win_open) win_cnt <= win_cnt + 1'b1;
    end

    // Mode register: loaded only by in-window writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg <= CFG_RESET;
        else if (wr_en && win_open) cfg <= wr_data;
    end

    // R9: a closed window freezes the register for the next cycle.
    a_r9_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !win_open |=> $stable(cfg));
    // R9: a reopen pulse makes the window visible on the next cycle.
    a_r9_reopen_visible: assert property (@(posedge clk) disable iff (!rst_n)
        reopen |=> win_open);

endmodule

// File: rtl/wdt_gate.sv
// Count qualifier.
// Resolves the effective timeout tap and whether the counter may advance in
// this cycle, from the mode register, the power state, the permanent strap
// and the selected tick source. When both are high, STOP takes precedence
// over HALT. Purely combinational.
module wdt_gate
    import wdt_pkg::*;
(
    input  wdt_cfg_t   cfg,
    input  logic       perm_en,
    input  logic       armed,
    input  logic       halt_mode,
    input  logic       stop_mode,
    input  logic       rc_tick,
    input  logic       xt_tick,
    output logic       run,
    output logic [1:0] tap_eff
);
    logic tick_sel;
    logic halt_ok;
    logic stop_ok;
    logic state_ok;

    // Effective tap and gating bits: the strap overrides the control bits.
    always_comb begin
        tick_sel = cfg.src_ext ? xt_tick : rc_tick;
        tap_eff  = perm_en ? PERM_TAP : cfg.tap;
        halt_ok  = perm_en | cfg.halt_run;
        stop_ok  = !cfg.src_ext && (perm_en | cfg.stop_run);
    end

    // Power-state qualifier and final run enable.
    always_comb begin
        if (stop_mode)      state_ok = stop_ok;
        else if (halt_mode) state_ok = halt_ok;
        else                state_ok = 1'b1;
        run = armed && tick_sel && state_ok;
    end

endmodule

// File: rtl/wdt_count.sv
// Counter chain and reset pulse generator.
// Counts qualified ticks up to the tap limit minus one, then raises a
// one-cycle reset pulse. A kick on the same edge wins over the terminal
// count. After a pulse the block disarms unless the permanent strap is set.
// Assumes perm_en changes only while rst_n is low.
module wdt_count
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 7,
    localparam int CNT_W = BASE_LOG2 + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             perm_en,
    input  logic             kick,
    input  logic             run,
    input  logic [1:0]       tap,
    input  logic             stop_mode,
    output logic             armed,
    output logic             fire,
    output logic [CNT_W-1:0] cnt,
    output logic             wdt_rst,
    output logic             stop_keep
);
    logic [CNT_W-1:0] lim_tab [4];
    logic [CNT_W-1:0] lim_sel;

    // Terminal value for each tap code.
    for (genvar i = 0; i < 4; i++) begin : g_lim
        assign lim_tab[i] = CNT_W'((64'd1 << (BASE_LOG2 + tap_shift(2'(i)))) - 64'd1);
    end

    // Terminal detect against the selected tap.
    always_comb begin
        lim_sel = lim_tab[tap];
        fire    = run && !kick && (cnt == lim_sel);
    end

    // Count, arm state and output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            armed     <= perm_en;
            wdt_rst   <= 1'b0;
            stop_keep <= 1'b0;
        end else begin
            wdt_rst   <= fire;
            stop_keep <= fire && stop_mode;
            if (kick) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (fire) begin
                armed <= perm_en;
                cnt   <= '0;
            end else if (run) begin
                cnt   <= cnt + 1'b1;
            end
        end
    end

    // R4: the reset output never lasts two cycles.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);
    // R3: an idle watchdog cannot produce a reset.
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !wdt_rst);
    // R5: a kick always suppresses the reset on the following cycle.
    a_r5_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wdt_rst);
    // R10: with the strap on, the watchdog stays armed.
    a_r10_perm_armed: assert property (@(posedge clk) disable iff (!rst_n)
        perm_en |-> armed);
    // R11: the context-keep flag only accompanies a reset pulse.
    a_r11_keep_with_rst: assert property (@(posedge clk) disable iff (!rst_n)
        stop_keep |-> wdt_rst);

endmodule

// File: rtl/mode_watchdog.sv
// Mode-aware watchdog top.
// Ties the mode register, the count qualifier and the counter chain
// together. A reset pulse or a STOP wake reopens the mode register's write
// window. Assumes kick, stop_wake and cfg_we are synchronous to clk.
module mode_watchdog
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2  = 7,
    parameter int WIN_CYCLES = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       perm_en,
    input  logic       rc_tick,
    input  logic       xt_tick,
    input  logic       halt_mode,
    input  logic       stop_mode,
    input  logic       stop_wake,
    input  logic       kick,
    input  logic       cfg_we,
    input  logic [4:0] cfg_wdata,
    output logic       wdt_rst,
    output logic       stop_keep,
    output logic [4:0] cfg_q,
    output logic       win_open
);
    localparam int CNT_W = BASE_LOG2 + 4;

    wdt_cfg_t         cfg;
    logic             armed;
    logic             run;
    logic             fire;
    logic [1:0]       tap_eff;
    logic [CNT_W-1:0] cnt;
    logic             reopen;

    // Window reopen sources: a terminal count or a STOP wake.
    always_comb reopen = fire | stop_wake;

    assign cfg_q = cfg;

    wdt_mode_reg #(.WIN_CYCLES(WIN_CYCLES)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_data  (wdt_cfg_t'(cfg_wdata)),
        .reopen   (reopen),
        .cfg      (cfg),
        .win_open (win_open)
    );

    wdt_gate u_gate (
        .cfg       (cfg),
        .perm_en   (perm_en),
        .armed     (armed),
        .halt_mode (halt_mode),
        .stop_mode (stop_mode),
        .rc_tick   (rc_tick),
        .xt_tick   (xt_tick),
        .run       (run),
        .tap_eff   (tap_eff)
    );

    wdt_count #(.BASE_LOG2(BASE_LOG2)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .perm_en   (perm_en),
        .kick      (kick),
        .run       (run),
        .tap       (tap_eff),
        .stop_mode (stop_mode),
        .armed     (armed),
        .fire      (fire),
        .cnt       (cnt),
        .wdt_rst   (wdt_rst),
        .stop_keep (stop_keep)
    );

    // R6: HALT with the halt bit clear freezes the count.
    a_r6_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_mode && !stop_mode && !perm_en && !cfg.halt_run && !kick)
        |=> $stable(cnt));
    // R7: STOP with the external source selected freezes the count.
    a_r7_ext_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_mode && cfg.src_ext && !kick) |=> $stable(cnt));

endmodule

// File: tb/mode_watchdog_tb.sv
// Self-checking bench for mode_watchdog. A behavioural reference model is
// compared with the outputs on every cycle, and directed checks measure the
// timeouts and the write window.
module mode_watchdog_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       perm_en = 1'b0;
    logic       rc_tick = 1'b1;
    logic       xt_tick = 1'b1;
    logic       halt_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       stop_wake = 1'b0;
    logic       kick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic       wdt_rst;
    logic       stop_keep;
    logic [4:0] cfg_q;
    logic       win_open;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;   // 125 MHz

    mode_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .perm_en(perm_en), .rc_tick(rc_tick),
        .xt_tick(xt_tick), .halt_mode(halt_mode), .stop_mode(stop_mode),
        .stop_wake(stop_wake), .kick(kick), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .wdt_rst(wdt_rst), .stop_keep(stop_keep),
        .cfg_q(cfg_q), .win_open(win_open)
    );

    // Reference model state.
    int m_cfg = 5, m_win = 0, m_cnt = 0;
    bit m_en = 0, m_pulse = 0, m_keep = 0, started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 5; m_win = 0; m_cnt = 0;
            m_en = perm_en; m_pulse = 0; m_keep = 0; started = 1;
        end else begin
            int tap, lim;
            bit ext, hrun, srun, tick, run, fire, allow;
            ext  = m_cfg[4];
            tap  = perm_en ? 1 : (m_cfg & 3);
            hrun = perm_en || m_cfg[2];
            srun = !ext && (perm_en || m_cfg[3]);
            tick = ext ? xt_tick : rc_tick;
            allow = stop_mode ? srun : (halt_mode ? hrun : 1'b1);
            run  = m_en && tick && allow;
            lim  = 1 << (7 + ((tap == 3) ? 4 : tap));
            fire = run && !kick && (m_cnt == lim - 1);
            m_pulse = fire;
            m_keep  = fire && stop_mode;
            if (kick) begin m_en = 1; m_cnt = 0; end
            else if (fire) begin m_en = perm_en; m_cnt = 0; end
            else if (run) m_cnt++;
            if (cfg_we && m_win < 60) m_cfg = cfg_wdata;
            if (fire || stop_wake) m_win = 0;
            else if (m_win < 60) m_win++;
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) if (started && rst_n) begin
        check({cur_req, " wdt_rst"},   wdt_rst,   m_pulse);
        check({cur_req, " stop_keep"}, stop_keep, m_keep);
        check({cur_req, " cfg_q"},     cfg_q,     m_cfg);
        check({cur_req, " win_open"},  win_open,  (m_win < 60));
    end

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(bit p);
        kick = 0; cfg_we = 0; stop_wake = 0;
        perm_en = p; rst_n = 0;
        step(3);
        rst_n = 1;
    endtask

    task automatic write_cfg(logic [4:0] v);
        cfg_we = 1; cfg_wdata = v; step(1); cfg_we = 0;
    endtask

    task automatic kick_once();
        kick = 1; step(1); kick = 0;
    endtask

    // Number of edges until wdt_rst is seen, or -1 if not within maxc.
    task automatic measure(output int k, input int maxc);
        int n = 0;
        k = -1;
        while (n < maxc) begin
            step(1); n++;
            if (wdt_rst) begin k = n; break; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        // R1 reset state
        cur_req = "R1"; do_reset(0); step(1);
        check("R1 wdt_rst", wdt_rst, 0); check("R1 cfg_q", cfg_q, 5);
        check("R1 win_open", win_open, 1); check("R1 stop_keep", stop_keep, 0);
        // R3 idle until kicked
        cur_req = "R3"; measure(k, 400); check("R3 idle no reset", k, -1);
        // R2 default tap, R4 single pulse then idle
        cur_req = "R2"; kick_once(); measure(k, 3000); check("R2 tap01", k, 256);
        cur_req = "R4"; step(1); check("R4 one cycle", wdt_rst, 0);
        measure(k, 600); check("R4 idle after pulse", k, -1);
        // R3 restart from latest kick, tap 00
        cur_req = "R3"; do_reset(0); write_cfg(5'b00100);
        kick_once(); step(50); kick_once(); measure(k, 1000);
        check("R3 restart tap00", k, 128);
        cur_req = "R2"; do_reset(0); write_cfg(5'b00110);
        kick_once(); measure(k, 1000); check("R2 tap10", k, 512);
        do_reset(0); write_cfg(5'b00111);
        kick_once(); measure(k, 3000); check("R2 tap11", k, 2048);
        // R5 kick on the terminal edge
        cur_req = "R5"; do_reset(0); write_cfg(5'b00100);
        kick_once(); step(127); kick = 1; step(1); kick = 0;
        check("R5 kick wins", wdt_rst, 0);
        measure(k, 500); check("R5 count restarted", k, 128);
        // R6 HALT gating
        cur_req = "R6"; do_reset(0); write_cfg(5'b00000);
        kick_once(); halt_mode = 1; measure(k, 300); check("R6 halt frozen", k, -1);
        halt_mode = 0; measure(k, 500); check("R6 resume", k, 128);
        do_reset(0); write_cfg(5'b00100); kick_once(); halt_mode = 1;
        measure(k, 500); check("R6 halt counts", k, 128); halt_mode = 0;
        // R7 / R11 STOP gating and context keep
        cur_req = "R7"; do_reset(0); write_cfg(5'b01100); kick_once(); stop_mode = 1;
        measure(k, 500); check("R7 stop counts", k, 128);
        cur_req = "R11"; check("R11 keep flag", stop_keep, 1);
        step(1); check("R11 cfg kept", cfg_q, 5'b01100); stop_mode = 0;
        cur_req = "R7"; do_reset(0); write_cfg(5'b00100); kick_once(); stop_mode = 1;
        measure(k, 300); check("R7 stop frozen", k, -1);
        stop_mode = 0; measure(k, 500); check("R7 resume", k, 128);
        do_reset(0); write_cfg(5'b11100); kick_once(); stop_mode = 1;
        measure(k, 300); check("R7 ext frozen in stop", k, -1); stop_mode = 0;
        // R8 tick source select
        cur_req = "R8"; do_reset(0); write_cfg(5'b10100); xt_tick = 0;
        kick_once(); measure(k, 300); check("R8 rc ignored", k, -1);
        xt_tick = 1; measure(k, 500); check("R8 ext counts", k, 128);
        do_reset(0); write_cfg(5'b00100); rc_tick = 0;
        kick_once(); measure(k, 300); check("R8 ext ignored", k, -1);
        rc_tick = 1; measure(k, 500); check("R8 rc counts", k, 128);
        // R9 write window
        cur_req = "R9"; do_reset(0); step(59); write_cfg(5'b00110);
        check("R9 edge 60 accepted", cfg_q, 5'b00110);
        check("R9 window closed", win_open, 0);
        write_cfg(5'b00000); check("R9 edge 61 ignored", cfg_q, 5'b00110);
        stop_wake = 1; step(1); stop_wake = 0;
        check("R9 wake reopens", win_open, 1);
        write_cfg(5'b00100); check("R9 write after wake", cfg_q, 5'b00100);
        step(70); check("R9 closed again", win_open, 0);
        kick_once(); measure(k, 500); check("R9 pulse tap00", k, 128);
        step(1); check("R9 reset reopens", win_open, 1);
        // R10 permanent mode: first write costs one counted edge, so 255
        cur_req = "R10"; halt_mode = 1; do_reset(1); write_cfg(5'b00000);
        measure(k, 3000); check("R10 armed from reset", k, 255);
        measure(k, 3000); check("R10 re-armed", k, 256); halt_mode = 0;
        stop_mode = 1; do_reset(1);
        measure(k, 3000); check("R10 stop rc counts", k, 256);
        do_reset(1); write_cfg(5'b10000);
        measure(k, 600); check("R10 stop ext frozen", k, -1); stop_mode = 0;
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule